// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block carries out one block load or block store over a sixteen-entry register list, one word per memory handshake. A start strobe presents the low 25 bits of the instruction word, the current value of the base register and the address of the instruction. The block then walks the selected registers in ascending index order. For each one it reads the register file and issues a memory write, or it issues a memory read and writes the returned word to the register file. It also updates the base register when the instruction asks for it.

Descending transfers are turned into an ascending walk that starts below the base. Two kinds of transfer are handled explicitly: a store that names the base register, and a transfer that touches the program counter (index 15). An empty register list gets a special treatment of its own. An external bank switch is steered by a user-bank output for the duration of the transfer. The sequencer signals the end of each instruction with a one-cycle done pulse and reports whether the instruction costs one extra internal cycle.

Top module: `xfer_seq`

## Requirements
- R1: The operation input is decoded as follows: bit 24 pre-step, bit 23 ascending, bit 22 user bank, bit 21 base update, bit 20 load (1) or store (0), bits 19:16 base register index, bits 15:0 register list (bit i selects register i). A start is accepted only when the block is idle.
- R2: With ascending set, the walk starts at the base and visits the listed registers in ascending index order at addresses that rise by 4. With pre-step set, 4 is added before the first access (base+4, base+8, ...). With pre-step clear, the first access is at the base itself.
- R3: With ascending clear and N registers listed, the walk starts at base-4N and still rises by 4 in ascending index order, with the pre-step sense inverted: pre-step set gives base-4N first, and pre-step clear gives base-4N+4 first.
- R4: With base update set and a non-empty list, the base register becomes base+4N when ascending and base-4N otherwise. On a load this write precedes the loads, so a loaded base value wins.
- R5: A store whose list contains the base register writes the old base value when the base is the lowest listed register. When the base is listed later and base update is set, it writes the updated base value instead.
- R6: Storing register 15 writes the instruction address plus 12. Loading register 15 raises the flush output for one cycle.
- R7: With an empty list, a load reads one word from the base address into register 15 and raises flush.
- R8: With an empty list, a store writes the instruction address plus 12 to base+4 (ascending, pre-step), base (ascending, post-step), base-0x40 (descending, pre-step) or base-0x3C (descending, post-step). With base update set, the base moves by +0x40 or -0x40.
- R9: When the user-bank bit is set, user_bank is high from the cycle after start through the done cycle, covering every memory access, and low in the cycle after done.
- R10: done is high for exactly one cycle per instruction, after every register write and any flush. done_icycle is 1 with done for a load and 0 for a store.
- R11: Only one memory request is outstanding at a time. mem_req, mem_we and mem_addr hold steady until mem_ready, and nothing is requested or written while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| instr_low | input | 25 | Bits 24:0 of the instruction word |
| base_val | input | 32 | Current value of the base register |
| pc_val | input | 32 | Address of the instruction |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (same cycle) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts / completes the request |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| user_bank | output | 1 | Select the user register bank |
| flush | output | 1 | One-cycle pipeline flush request |
| done | output | 1 | One-cycle end-of-instruction pulse |
| done_icycle | output | 1 | With done: one extra internal cycle |

## Verification
A stale beat counter or remaining-list mask shows up at the ports on the very next handshake. The next mem_addr is then off by a multiple of 4, or the rf_waddr of a load names a register that is not listed. A wrong sequence state shows as a base write in the wrong order: a loaded base would be overwritten, or a stored base would carry the wrong value. It also shows as a missing flush, or as a done that comes before the flush rather than in the cycle after it. A user-bank flag that is not released stays visible on user_bank in the first idle cycle after done.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int LIST_W = 16;
  localparam int IDX_W  = $clog2(LIST_W);
  localparam int OP_W   = 5 + IDX_W + LIST_W;
  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(LIST_W - 1);

  // Field order matches the operation bit positions, so a cast decodes it.
  typedef struct packed {
    logic             pre;
    logic             up;
    logic             usr;
    logic             wb;
    logic             ld;
    logic [IDX_W-1:0] rn;
    logic [LIST_W-1:0] list;
  } op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB_LD,
    ST_MOVE,
    ST_WB_ST,
    ST_FLUSH,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/mrt_decode.sv
module mrt_decode
  import mrt_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 5
) (
  input  op_t               op,
  input  logic [WORD_W-1:0] base,
  output logic              empty,
  output logic              pre_eff,
  output logic [WORD_W-1:0] walk_start,
  output logic [WORD_W-1:0] wb_base,
  output logic [WORD_W-1:0] empty_addr
);
  localparam logic [WORD_W-1:0] STEP       = WORD_W'(4);
  localparam logic [WORD_W-1:0] EMPTY_SPAN = WORD_W'(64);
  localparam logic [WORD_W-1:0] DN_POST    = WORD_W'(60);

  function automatic logic [CNT_W-1:0] f_count(input logic [LIST_W-1:0] l);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < LIST_W; i++) c = c + CNT_W'(l[i]);
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] f_span(input logic [CNT_W-1:0] n);
    return WORD_W'(n) << 2;
  endfunction

  function automatic logic [WORD_W-1:0] f_empty_addr(input logic [WORD_W-1:0] b,
                                                     input logic up, input logic pre,
                                                     input logic ld);
    if (ld)       return b;
    if (up && pre) return b + STEP;
    if (up)        return b;
    if (pre)       return b - EMPTY_SPAN;
    return b - DN_POST;
  endfunction

  logic [CNT_W-1:0]  count;
  logic [WORD_W-1:0] span;

  assign count      = f_count(op.list);
  assign span       = empty ? EMPTY_SPAN : f_span(count);
  assign empty      = (op.list == '0);
  assign pre_eff    = op.up ? op.pre : ~op.pre;
  assign walk_start = op.up ? base : base - span;
  assign wb_base    = op.up ? base + span : base - span;
  assign empty_addr = f_empty_addr(base, op.up, op.pre, op.ld);
endmodule

// File: rtl/mrt_pick.sv
module mrt_pick #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  pend,
  output logic [NREG-1:0]  onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any,
  output logic             last
);
  logic [NREG:0] below;
  assign below[0] = 1'b0;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_chain
      assign below[g+1] = below[g] | pend[g];
      assign onehot[g]  = pend[g] & ~below[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < NREG; i++)
      if (onehot[i]) idx = idx | IDX_W'(i);
  end

  assign any  = below[NREG];
  assign last = any && ((pend & ~onehot) == '0);
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import mrt_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   instr_low,
  input  logic [WORD_W-1:0] base_val,
  input  logic [WORD_W-1:0] pc_val,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [WORD_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [WORD_W-1:0] rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              user_bank,
  output logic              flush,
  output logic              done,
  output logic              done_icycle
);
  localparam int CNT_W = $clog2(LIST_W + 1);
  localparam logic [WORD_W-1:0] PC_OFS = WORD_W'(12);
  localparam logic [WORD_W-1:0] STEP   = WORD_W'(4);

  seq_state_t        st_q, st_d;
  op_t               op_q, op_in;
  logic [WORD_W-1:0] base_q, pc_q;
  logic [LIST_W-1:0] rem_q;
  logic [CNT_W-1:0]  beat_q;
  logic              ub_q;

  logic              empty, pre_eff;
  logic [WORD_W-1:0] walk_start, wb_base, empty_addr, walk_addr, st_val;
  logic [LIST_W-1:0] pick_onehot;
  logic [IDX_W-1:0]  pick_idx, cur_idx;
  logic              pick_any, pick_last;

  // named internal events used by the checks below
  logic in_move, beat_fire, beat_last;

  assign op_in = op_t'(instr_low);

  mrt_decode #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dec (
    .op(op_q), .base(base_q), .empty(empty), .pre_eff(pre_eff),
    .walk_start(walk_start), .wb_base(wb_base), .empty_addr(empty_addr)
  );

  mrt_pick #(.NREG(LIST_W), .IDX_W(IDX_W)) u_pick (
    .pend(rem_q), .onehot(pick_onehot), .idx(pick_idx),
    .any(pick_any), .last(pick_last)
  );

  assign in_move   = (st_q == ST_MOVE);
  assign beat_fire = in_move && mem_ready;
  assign beat_last = empty || pick_last;
  assign cur_idx   = empty ? PC_IDX : pick_idx;
  assign walk_addr = walk_start + (WORD_W'(beat_q) << 2) + (pre_eff ? STEP : '0);

  // store data selection
  always_comb begin
    if (cur_idx == PC_IDX)
      st_val = pc_q + PC_OFS;
    else if ((cur_idx == op_q.rn) && op_q.wb && (beat_q != '0))
      st_val = wb_base;
    else
      st_val = rf_rdata;
  end

  assign rf_raddr  = cur_idx;
  assign mem_req   = in_move;
  assign mem_we    = in_move && !op_q.ld;
  assign mem_addr  = empty ? empty_addr : walk_addr;
  assign mem_wdata = st_val;

  // register-file write port
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = op_q.rn;
    rf_wdata = wb_base;
    case (st_q)
      ST_WB_LD, ST_WB_ST: rf_we = 1'b1;
      ST_MOVE: if (op_q.ld && mem_ready) begin
        rf_we    = 1'b1;
        rf_waddr = cur_idx;
        rf_wdata = mem_rdata;
      end
      default: ;
    endcase
  end

  // sequence control
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start) st_d = (op_in.ld && op_in.wb) ? ST_WB_LD : ST_MOVE;
      ST_WB_LD: st_d = ST_MOVE;
      ST_MOVE:  if (mem_ready && beat_last) begin
        if (op_q.ld && (cur_idx == PC_IDX)) st_d = ST_FLUSH;
        else if (!op_q.ld && op_q.wb)       st_d = ST_WB_ST;
        else                                st_d = ST_DONE;
      end
      ST_WB_ST: st_d = ST_DONE;
      ST_FLUSH: st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      base_q <= '0;
      pc_q   <= '0;
      rem_q  <= '0;
      beat_q <= '0;
      ub_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if ((st_q == ST_IDLE) && start) begin
        op_q   <= op_in;
        base_q <= base_val;
        pc_q   <= pc_val;
        rem_q  <= op_in.list;
        beat_q <= '0;
        ub_q   <= op_in.usr;
      end else if (beat_fire) begin
        rem_q  <= rem_q & ~pick_onehot;
        beat_q <= beat_q + 1'b1;
      end else if (st_q == ST_DONE) begin
        ub_q <= 1'b0;
      end
    end
  end

  assign user_bank   = ub_q;
  assign flush       = (st_q == ST_FLUSH);
  assign done        = (st_q == ST_DONE);
  assign done_icycle = done && op_q.ld;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_IDLE) |-> !mem_req && !rf_we); // R11
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) beat_fire && !beat_last |=> mem_addr == $past(mem_addr) + STEP); // R2
  AST_MOVE_WORK: assert property (@(posedge clk) disable iff (!rst_n) in_move && !empty |-> pick_any); // R3
  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n) flush |=> done); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_UB_KEEP: assert property (@(posedge clk) disable iff (!rst_n) user_bank && !done |=> user_bank); // R9
  AST_UB_OFF: assert property (@(posedge clk) disable iff (!rst_n) done |=> !user_bank); // R9
endmodule

// File: tb/sim_xfer_seq.sv
module sim_xfer_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [24:0] instr_low = '0;
  logic [31:0] base_val = '0, pc_val = '0;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata;
  logic        rf_we, mem_req, mem_we, mem_ready, user_bank, flush, done, done_icycle;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_seq u0 (.*);

  // register file and memory models
  logic [31:0] rf [16];
  logic [31:0] mem [256];
  logic        set_rf = 1'b0, set_mem = 1'b0;
  logic [31:0] set_addr = '0, set_val = '0;
  logic [1:0]  lat = 2'd0, wcnt;

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_ready = mem_req && (wcnt >= lat);

  // access log
  logic [31:0] log_addr [256];
  logic [31:0] log_dat  [256];
  logic        log_we   [256];
  int nlog = 0, nflush = 0, ndone = 0, ub_low = 0, cyc = 0, flush_cyc = 0, done_cyc = 0;
  logic icyc_seen = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (set_rf) rf[set_addr[3:0]] <= set_val;
    else if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (set_mem) mem[set_addr[9:2]] <= set_val;
    else if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (!rst_n) wcnt <= '0;
    else if (mem_req && !mem_ready) wcnt <= wcnt + 1'b1;
    else wcnt <= '0;
    if (mem_req && mem_ready) begin
      log_addr[nlog[7:0]] <= mem_addr;
      log_we[nlog[7:0]]   <= mem_we;
      log_dat[nlog[7:0]]  <= mem_we ? mem_wdata : mem_rdata;
      nlog <= nlog + 1;
      if (!user_bank) ub_low <= ub_low + 1;
    end
    if (flush) begin nflush <= nflush + 1; flush_cyc <= cyc; end
    if (done) begin ndone <= ndone + 1; done_cyc <= cyc; icyc_seen <= done_icycle; end
  end

  int nchk = 0, nfail = 0;
  int lb, fb, ub0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_rf(input int idx, input logic [31:0] v);
    set_rf = 1'b1; set_addr = 32'(idx); set_val = v;
    @(negedge clk); set_rf = 1'b0;
  endtask

  task automatic wr_mem(input logic [31:0] a, input logic [31:0] v);
    set_mem = 1'b1; set_addr = a; set_val = v;
    @(negedge clk); set_mem = 1'b0;
  endtask

  function automatic logic [24:0] mkop(input logic pre, up, usr, wb, ld,
                                       input logic [3:0] rn, input logic [15:0] list);
    return {pre, up, usr, wb, ld, rn, list};
  endfunction

  task automatic run(input logic [24:0] op, input logic [31:0] pc);
    int d0;
    lb = nlog; fb = nflush; ub0 = ub_low; d0 = ndone;
    instr_low = op; base_val = rf[op[19:16]]; pc_val = pc; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (ndone == d0) @(negedge clk);
  endtask

  // R1 R2 R4 R10: ascending post-step load with base update
  task automatic t_ld_up_post();
    wr_rf(0, 32'h100);
    wr_mem(32'h100, 32'hA1A1_0001); wr_mem(32'h104, 32'hA3A3_0003); wr_mem(32'h108, 32'hA5A5_0005);
    run(mkop(0, 1, 0, 1, 1, 4'd0, 16'h002A), 32'h0);
    chk("R2 count", 32'(nlog - lb), 3);
    chk("R2 addr0", log_addr[lb], 32'h100);
    chk("R2 addr2", log_addr[lb+2], 32'h108);
    chk("R1 load dir", 32'(log_we[lb]), 0);
    chk("R1 reg3", rf[3], 32'hA3A3_0003);
    chk("R1 reg5", rf[5], 32'hA5A5_0005);
    chk("R4 up update", rf[0], 32'h10C);
    chk("R10 load icycle", 32'(icyc_seen), 1);
    chk("R6 no flush", 32'(nflush - fb), 0);
  endtask

  // R2 R10: ascending pre-step store, no update
  task automatic t_st_up_pre();
    wr_rf(7, 32'h100); wr_rf(2, 32'h2222_2222); wr_rf(4, 32'h4444_4444);
    run(mkop(1, 1, 0, 0, 0, 4'd7, 16'h0014), 32'h0);
    chk("R2 pre addr0", log_addr[lb], 32'h104);
    chk("R2 pre addr1", log_addr[lb+1], 32'h108);
    chk("R2 store data", mem[32'h108 >> 2], 32'h4444_4444);
    chk("R4 no update", rf[7], 32'h100);
    chk("R10 store icycle", 32'(icyc_seen), 0);
  endtask

  // R3 R4: descending pre-step store with update
  task automatic t_st_dn_pre();
    wr_rf(8, 32'h200);
    for (int i = 0; i < 4; i++) wr_rf(i, 32'hD000_0000 + 32'(i));
    run(mkop(1, 0, 0, 1, 0, 4'd8, 16'h000F), 32'h0);
    chk("R3 dn pre addr0", log_addr[lb], 32'h1F0);
    chk("R3 dn pre addr3", log_addr[lb+3], 32'h1FC);
    chk("R3 dn order", mem[32'h1F4 >> 2], 32'hD000_0001);
    chk("R4 dn update", rf[8], 32'h1F0);
  endtask

  // R3: descending post-step load
  task automatic t_ld_dn_post();
    wr_rf(9, 32'h200);
    wr_mem(32'h1FC, 32'h4444_AAAA); wr_mem(32'h200, 32'h6666_BBBB);
    run(mkop(0, 0, 0, 0, 1, 4'd9, 16'h0050), 32'h0);
    chk("R3 dn post addr0", log_addr[lb], 32'h1FC);
    chk("R3 dn post addr1", log_addr[lb+1], 32'h200);
    chk("R3 reg6", rf[6], 32'h6666_BBBB);
    chk("R4 base kept", rf[9], 32'h200);
  endtask

  // R5: base register inside a store list
  task automatic t_base_in_list();
    wr_rf(1, 32'h100); wr_rf(2, 32'h2BAD_0002);
    run(mkop(0, 1, 0, 1, 0, 4'd1, 16'h0006), 32'h0);
    chk("R5 base first old", log_dat[lb], 32'h100);
    chk("R5 base first update", rf[1], 32'h108);
    wr_rf(1, 32'h1111_0001); wr_rf(2, 32'h140);
    run(mkop(0, 1, 0, 1, 0, 4'd2, 16'h0006), 32'h0);
    chk("R5 base later addr", log_addr[lb+1], 32'h144);
    chk("R5 base later new", log_dat[lb+1], 32'h148);
  endtask

  // R6: program counter in the list
  task automatic t_pc_in_list();
    wr_rf(10, 32'h180); wr_rf(0, 32'h0F0F_0F0F);
    run(mkop(0, 1, 0, 0, 0, 4'd10, 16'h8001), 32'h1000);
    chk("R6 pc store addr", log_addr[lb+1], 32'h184);
    chk("R6 pc store value", log_dat[lb+1], 32'h100C);
    chk("R6 store no flush", 32'(nflush - fb), 0);
    wr_mem(32'h184, 32'h2000);
    run(mkop(0, 1, 0, 0, 1, 4'd10, 16'h8001), 32'h1000);
    chk("R6 pc loaded", rf[15], 32'h2000);
    chk("R6 load flush", 32'(nflush - fb), 1);
    chk("R10 done after flush", 32'(done_cyc - flush_cyc), 1);
  endtask

  // R7 R8: empty list
  task automatic t_empty();
    wr_rf(11, 32'h180); wr_mem(32'h180, 32'hCAFE_0000);
    run(mkop(0, 1, 0, 1, 1, 4'd11, 16'h0000), 32'h0);
    chk("R7 one access", 32'(nlog - lb), 1);
    chk("R7 pc from base", rf[15], 32'hCAFE_0000);
    chk("R7 flush", 32'(nflush - fb), 1);
    chk("R8 load update", rf[11], 32'h1C0);
    wr_rf(12, 32'h200);
    run(mkop(1, 1, 0, 0, 0, 4'd12, 16'h0000), 32'h3000);
    chk("R8 up pre addr", log_addr[lb], 32'h204);
    chk("R8 store value", log_dat[lb], 32'h300C);
    run(mkop(0, 1, 0, 0, 0, 4'd12, 16'h0000), 32'h3000);
    chk("R8 up post addr", log_addr[lb], 32'h200);
    run(mkop(1, 0, 0, 0, 0, 4'd12, 16'h0000), 32'h3000);
    chk("R8 dn pre addr", log_addr[lb], 32'h1C0);
    run(mkop(0, 0, 0, 1, 0, 4'd12, 16'h0000), 32'h3000);
    chk("R8 dn post addr", log_addr[lb], 32'h1C4);
    chk("R8 dn update", rf[12], 32'h1C0);
    chk("R8 one access", 32'(nlog - lb), 1);
  endtask

  // R9: user bank held across the transfer
  task automatic t_user_bank();
    wr_rf(13, 32'h100);
    run(mkop(0, 1, 1, 0, 0, 4'd13, 16'h0003), 32'h0);
    chk("R9 high on every access", 32'(ub_low - ub0), 0);
    chk("R9 released", 32'(user_bank), 0);
    run(mkop(0, 1, 0, 0, 0, 4'd13, 16'h0003), 32'h0);
    chk("R9 low when clear", 32'(ub_low - ub0), 2);
  endtask

  // R11: slow memory
  task automatic t_slow_mem();
    lat = 2'd2;
    wr_rf(0, 32'h100);
    wr_mem(32'h104, 32'h5151_5151);
    run(mkop(0, 1, 0, 0, 1, 4'd0, 16'h0030), 32'h0);
    chk("R11 one handshake per word", 32'(nlog - lb), 2);
    chk("R11 addr held", log_addr[lb+1], 32'h104);
    chk("R11 data", rf[5], 32'h5151_5151);
    lat = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset done", 32'(done), 0);
    chk("R11 reset req", 32'(mem_req), 0);
    chk("R11 reset rf_we", 32'(rf_we), 0);
    chk("R9 reset bank", 32'(user_bank), 0);
    t_ld_up_post();
    t_st_up_pre();
    t_st_dn_pre();
    t_ld_dn_post();
    t_base_in_list();
    t_pc_in_list();
    t_empty();
    t_user_bank();
    t_slow_mem();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail + 1);
    $finish;
  end
endmodule